// File: doc/BRIEF.md
# Single-Cycle Execute Datapath

This block is the execute and state part of a single-cycle 32-bit processor. Each cycle it takes one instruction word and a set of already decoded control points. From the word it takes the source and destination register numbers and the 16-bit immediate. It reads two registers at once. It extends the immediate, either with zeros or with the sign bit. It picks the second ALU operand and runs one of three ALU operations. In the same cycle it presents a data-memory word. The register file write and the memory write both happen on the rising clock edge that ends the cycle.

The block supports register add and subtract, or with an immediate, word load, word store, and the equality compare used by conditional branches. For that compare, the zero flag is the result. Next-address logic and instruction decoding stay outside the block. Two observation ports, one for a register number and one for a memory word index, let the enclosing design or a test environment read the stored state without disturbing it.

Top module: `exec_datapath`

## Requirements
- R1: While the active-low reset is low, every register reads as zero. Reset leaves the data-memory contents unchanged.
- R2: The ALU operation code behaves as follows: 00 adds, with the result wrapping modulo 2^32. 01 subtracts the second operand from the first. 10 and 11 give the bitwise OR.
- R3: The immediate is instr[15:0]. When extOp is 0 it is zero-extended to 32 bits. When extOp is 1 it is sign-extended from bit 15.
- R4: The first operand is the register selected by instr[25:21]. The second operand is the register selected by instr[20:16] when aluSrc is 0, and the extended immediate when aluSrc is 1. Register reads are combinational.
- R5: The destination register number is instr[20:16] when regDst is 0 and instr[15:11] when regDst is 1. The register is written at the rising edge only while regWr is 1. Otherwise every register holds its value.
- R6: The register write data is the ALU result when memToReg is 0 and the data-memory read word when memToReg is 1.
- R7: The data memory holds 256 words, indexed by ALU result bits [9:2], and its read is combinational. At the rising edge with memWr 1, the word selected by instr[20:16] is stored at that index. With memWr 0, no word changes.
- R8: Register 0 always reads as zero, and a write addressed to it has no effect.
- R9: zero is 1 exactly when the ALU result is all zeros. A subtract of two equal registers therefore sets it, and a subtract of two unequal registers clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the register file |
| instr | input | 32 | Instruction word supplying register numbers and immediate |
| regDst | input | 1 | Destination select: 0 rt field, 1 rd field |
| extOp | input | 1 | Immediate extension: 0 zero, 1 sign |
| aluSrc | input | 1 | Second operand: 0 register, 1 immediate |
| aluCtl | input | 2 | ALU operation: 00 add, 01 subtract, 1x or |
| memToReg | input | 1 | Write-back source: 0 ALU, 1 memory |
| regWr | input | 1 | Register file write enable |
| memWr | input | 1 | Data memory write enable |
| dbgRegAddr | input | 5 | Register number for the observation read |
| dbgMemAddr | input | 8 | Memory word index for the observation read |
| aluResult | output | 32 | ALU result of the current cycle |
| zero | output | 1 | High when the ALU result is zero |
| dbgRegData | output | 32 | Contents of the observed register |
| dbgMemData | output | 32 | Contents of the observed memory word |

## Verification
The bench builds the block with its default parameters: 32-bit words and an 8-bit memory word index. At that size every one of the 256 memory words and all 32 registers can be compared against a reference model after each instruction. The full index width also lets a store through a sign-extended negative offset land at a high word index, in a different place from the low index used by the positive offsets. The small size also makes it cheap to clear the whole memory through ordinary stores before the checks begin.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned IMM_W  = 16;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_OR   = 2'b10,
    ALU_OR_B = 2'b11
  } aluOp_e;

  typedef struct packed {
    logic   regDst;
    logic   extOp;
    logic   aluSrc;
    aluOp_e aluOp;
    logic   memToReg;
    logic   regWr;
    logic   memWr;
  } strobes_t;
endpackage

// File: rtl/exec_strobes.sv
module exec_strobes
  import exec_pkg::*;
(
  input  logic       regDst,
  input  logic       extOp,
  input  logic       aluSrc,
  input  logic [1:0] aluCtl,
  input  logic       memToReg,
  input  logic       regWr,
  input  logic       memWr,
  output strobes_t   strobes
);
  always_comb begin
    strobes.regDst   = regDst;
    strobes.extOp    = extOp;
    strobes.aluSrc   = aluSrc;
    strobes.aluOp    = aluOp_e'(aluCtl);
    strobes.memToReg = memToReg;
    strobes.regWr    = regWr;
    strobes.memWr    = memWr;
  end
endmodule

// File: rtl/exec_regfile.sv
module exec_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] readAddrA,
  input  logic [ADDR_W-1:0] readAddrB,
  input  logic [ADDR_W-1:0] writeAddr,
  input  logic [DATA_W-1:0] writeData,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] readDataA,
  output logic [DATA_W-1:0] readDataB,
  output logic [DATA_W-1:0] peekData
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[g] <= '0;
      end else if (writeEn && writeAddr == ADDR_W'(g)) begin
        regs[g] <= writeData;
      end
    end
  end

  assign readDataA = regs[readAddrA];
  assign readDataB = regs[readAddrB];
  assign peekData  = regs[peekAddr];
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluOp_e           op,
  output logic [WIDTH-1:0] result,
  output logic             isZero
);
  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      default: result = opA | opB;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/exec_dmem.sv
module exec_dmem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_AW = 8
) (
  input  logic               clk,
  input  logic               writeEn,
  input  logic [WORD_AW-1:0] wordAddr,
  input  logic [DATA_W-1:0]  writeData,
  input  logic [WORD_AW-1:0] peekAddr,
  output logic [DATA_W-1:0]  readData,
  output logic [DATA_W-1:0]  peekData
);
  localparam int unsigned DEPTH = 1 << WORD_AW;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (writeEn) begin
      words[wordAddr] <= writeData;
    end
  end

  assign readData = words[wordAddr];
  assign peekData = words[peekAddr];
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instr,
  input  logic              regDst,
  input  logic              extOp,
  input  logic              aluSrc,
  input  logic [1:0]        aluCtl,
  input  logic              memToReg,
  input  logic              regWr,
  input  logic              memWr,
  input  logic [4:0]        dbgRegAddr,
  input  logic [MEM_AW-1:0] dbgMemAddr,
  output logic [31:0]       aluResult,
  output logic              zero,
  output logic [31:0]       dbgRegData,
  output logic [31:0]       dbgMemData
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  strobes_t          strobes;
  logic [REG_AW-1:0] rsField, rtField, rdField, destReg;
  logic [IMM_W-1:0]  immField;
  logic [DATA_W-1:0] busA, busB, immExt, opB, memRead, wbData;

  assign rsField  = instr[25:21];
  assign rtField  = instr[20:16];
  assign rdField  = instr[15:11];
  assign immField = instr[IMM_W-1:0];

  exec_strobes uStrobes (
    .regDst(regDst), .extOp(extOp), .aluSrc(aluSrc), .aluCtl(aluCtl),
    .memToReg(memToReg), .regWr(regWr), .memWr(memWr), .strobes(strobes)
  );

  assign destReg = strobes.regDst ? rdField : rtField;
  assign immExt  = {{EXT_W{strobes.extOp & immField[IMM_W-1]}}, immField};
  assign opB     = strobes.aluSrc ? immExt : busB;
  assign wbData  = strobes.memToReg ? memRead : aluResult;

  exec_regfile #(.DATA_W(DATA_W), .ADDR_W(REG_AW)) uRegs (
    .clk(clk), .rstN(rstN),
    .readAddrA(rsField), .readAddrB(rtField),
    .writeAddr(destReg), .writeData(wbData), .writeEn(strobes.regWr),
    .peekAddr(dbgRegAddr),
    .readDataA(busA), .readDataB(busB), .peekData(dbgRegData)
  );

  exec_alu #(.WIDTH(DATA_W)) uAlu (
    .opA(busA), .opB(opB), .op(strobes.aluOp),
    .result(aluResult), .isZero(zero)
  );

  exec_dmem #(.DATA_W(DATA_W), .WORD_AW(MEM_AW)) uMem (
    .clk(clk), .writeEn(strobes.memWr),
    .wordAddr(aluResult[MEM_AW+1:2]), .writeData(busB),
    .peekAddr(dbgMemAddr),
    .readData(memRead), .peekData(dbgMemData)
  );
endmodule

// File: rtl/exec_datapath_chk.sv
module exec_datapath_chk #(
  parameter int unsigned MEM_AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       instr,
  input logic [1:0]        aluCtl,
  input logic              regWr,
  input logic              memWr,
  input logic [31:0]       busA,
  input logic [31:0]       opB,
  input logic [31:0]       aluY,
  input logic              zero,
  input logic [4:0]        dbgRegAddr,
  input logic [31:0]       dbgRegData,
  input logic [MEM_AW-1:0] dbgMemAddr,
  input logic [31:0]       dbgMemData
);
  // R8: a source field of 0 always yields a zero operand
  a_r8_reg0_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (instr[25:21] == 5'd0) |-> (busA == 32'd0));

  // R9: subtracting equal operands raises the zero flag
  a_r9_equal_sets_zero: assert property (@(posedge clk) disable iff (!rstN)
    (aluCtl == 2'b01 && busA == opB) |-> zero);

  // R2: an add result minus the second operand gives back the first
  a_r2_add_inverts: assert property (@(posedge clk) disable iff (!rstN)
    (aluCtl == 2'b00) |-> ((aluY - opB) == busA));

  // R2: an OR result covers every set bit of both operands
  a_r2_or_covers: assert property (@(posedge clk) disable iff (!rstN)
    aluCtl[1] |-> (((aluY & busA) == busA) && ((aluY & opB) == opB)));

  // R5: without a register write, the observed register does not change
  a_r5_reg_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr) |=> (!$stable(dbgRegAddr) || $stable(dbgRegData)));

  // R7: without a memory write, the observed word does not change
  a_r7_mem_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!memWr) |=> (!$stable(dbgMemAddr) || $stable(dbgMemData)));
endmodule

bind exec_datapath exec_datapath_chk #(.MEM_AW(MEM_AW)) uChk (
  .clk(clk), .rstN(rstN), .instr(instr), .aluCtl(aluCtl),
  .regWr(regWr), .memWr(memWr), .busA(busA), .opB(opB),
  .aluY(aluResult), .zero(zero),
  .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData),
  .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
);

// File: tb/exec_datapath_test.sv
`timescale 1ns/1ps
module exec_datapath_test;
  localparam int MEM_AW = 8;
  localparam int NWORD = 1 << MEM_AW;

  // kind codes used in the vector table
  localparam logic [2:0] K_ADD = 3'd0, K_SUB = 3'd1, K_ORI = 3'd2,
                         K_LW  = 3'd3, K_SW  = 3'd4, K_BEQ = 3'd5;
  localparam int NVEC = 14;
  // each entry: kind, rs, rt, low 16 bits (rd in [15:11] for register ops)
  localparam logic [28:0] VEC [NVEC] = '{
    {K_ORI, 5'd0, 5'd1, 16'h1234},
    {K_ORI, 5'd0, 5'd2, 16'hFFFF},
    {K_ADD, 5'd1, 5'd2, 5'd3, 11'd0},
    {K_SUB, 5'd2, 5'd1, 5'd4, 11'd0},
    {K_SUB, 5'd1, 5'd2, 5'd5, 11'd0},
    {K_SW,  5'd0, 5'd3, 16'h0008},
    {K_SW,  5'd1, 5'd5, 16'hFFF0},
    {K_LW,  5'd0, 5'd6, 16'h0008},
    {K_LW,  5'd1, 5'd7, 16'hFFF0},
    {K_ADD, 5'd3, 5'd4, 5'd0, 11'd0},
    {K_BEQ, 5'd6, 5'd3, 16'h0000},
    {K_BEQ, 5'd6, 5'd4, 16'h0000},
    {K_ORI, 5'd0, 5'd0, 16'h0005},
    {K_ADD, 5'd5, 5'd5, 5'd8, 11'd0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] instr = '0;
  logic regDst = 0, extOp = 0, aluSrc = 0, memToReg = 0, regWr = 0, memWr = 0;
  logic [1:0] aluCtl = '0;
  logic [4:0] dbgRegAddr = '0;
  logic [MEM_AW-1:0] dbgMemAddr = '0;
  logic [31:0] aluResult, dbgRegData, dbgMemData;
  logic zero;

  int checks = 0, errors = 0;
  logic [31:0] refReg [32];
  logic [31:0] refMem [NWORD];

  always #5 clk = ~clk;

  exec_datapath #(.MEM_AW(MEM_AW)) uut (
    .clk(clk), .rstN(rstN), .instr(instr), .regDst(regDst), .extOp(extOp),
    .aluSrc(aluSrc), .aluCtl(aluCtl), .memToReg(memToReg), .regWr(regWr),
    .memWr(memWr), .dbgRegAddr(dbgRegAddr), .dbgMemAddr(dbgMemAddr),
    .aluResult(aluResult), .zero(zero), .dbgRegData(dbgRegData),
    .dbgMemData(dbgMemData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // compare every register and every memory word with the model
  task automatic cmpState(input string tagR, input string tagM);
    int badR = 0, badM = 0;
    logic [31:0] firstAct = '0, firstExp = '0;
    for (int i = 0; i < 32; i++) begin
      dbgRegAddr = 5'(i);
      #0.1;
      if (dbgRegData !== refReg[i]) begin
        if (badR == 0) begin firstAct = dbgRegData; firstExp = refReg[i]; end
        badR++;
      end
    end
    chk(tagR, (badR == 0) ? 32'd0 : firstAct, (badR == 0) ? 32'd0 : firstExp);
    for (int i = 0; i < NWORD; i++) begin
      dbgMemAddr = MEM_AW'(i);
      #0.1;
      if (dbgMemData !== refMem[i]) begin
        if (badM == 0) begin firstAct = dbgMemData; firstExp = refMem[i]; end
        badM++;
      end
    end
    chk(tagM, (badM == 0) ? 32'd0 : firstAct, (badM == 0) ? 32'd0 : firstExp);
  endtask

  // drive one instruction with its controls, check outputs, update the model
  task automatic applyOp(input logic [31:0] ins, input logic rDst, input logic eOp,
                         input logic aSrc, input logic [1:0] aCtl, input logic m2r,
                         input logic rWr, input logic mWr, input string tag);
    logic [31:0] a, b, imm, opb, y, wb;
    logic [4:0] dest;
    logic [MEM_AW-1:0] idx;
    @(negedge clk);
    instr = ins; regDst = rDst; extOp = eOp; aluSrc = aSrc; aluCtl = aCtl;
    memToReg = m2r; regWr = rWr; memWr = mWr;
    a   = refReg[ins[25:21]];
    b   = refReg[ins[20:16]];
    imm = eOp ? {{16{ins[15]}}, ins[15:0]} : {16'h0, ins[15:0]};
    opb = aSrc ? imm : b;
    y   = aCtl[1] ? (a | opb) : (aCtl[0] ? a - opb : a + opb);
    idx = y[MEM_AW+1:2];
    wb  = m2r ? refMem[idx] : y;
    dest = rDst ? ins[15:11] : ins[20:16];
    #2;
    chk({tag, " result"}, aluResult, y);
    chk("R9 zero flag", {31'd0, zero}, {31'd0, (y == 32'd0)});
    if (rWr && dest != 5'd0) refReg[dest] = wb;
    if (mWr) refMem[idx] = b;
    @(posedge clk);
    #1;
    regWr = 0; memWr = 0;
  endtask

  function automatic logic [31:0] mkI(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [15:0] low);
    return {6'h00, rs, rt, low};
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) refReg[i] = '0;
    for (int i = 0; i < NWORD; i++) refMem[i] = '0;
    repeat (3) @(posedge clk);
    // R1: registers are zero while reset is held
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      dbgRegAddr = 5'(i);
      #0.1;
      chk("R1 reset register", dbgRegData, 32'd0);
    end
    rstN = 1'b1;

    // clear memory through ordinary stores of register 0 (R7)
    for (int k = 0; k < NWORD; k++)
      applyOp(mkI(5'd0, 5'd0, 16'(k * 4)), 0, 1, 1, 2'b00, 0, 0, 1, "R7 clear");
    cmpState("R7 registers after clear", "R7 memory after clear");

    // table walk: every entry checked against the model
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] kind;
      logic [31:0] ins;
      kind = VEC[v][28:26];
      ins  = mkI(VEC[v][25:21], VEC[v][20:16], VEC[v][15:0]);
      case (kind)
        K_ADD: applyOp(ins, 1, 0, 0, 2'b00, 0, 1, 0, "R2 add");
        K_SUB: applyOp(ins, 1, 0, 0, 2'b01, 0, 1, 0, "R2 sub");
        K_ORI: applyOp(ins, 0, 0, 1, 2'b10, 0, 1, 0, "R3 zero-ext or");
        K_LW:  applyOp(ins, 0, 1, 1, 2'b00, 1, 1, 0, "R4 load address");
        K_SW:  applyOp(ins, 0, 1, 1, 2'b00, 0, 0, 1, "R4 store address");
        default: applyOp(ins, 0, 0, 0, 2'b01, 0, 0, 0, "R9 compare");
      endcase
      cmpState("R5 registers", "R6 R7 memory");
    end

    // R8: register 0 stays zero after writes aimed at it
    dbgRegAddr = 5'd0;
    #0.1;
    chk("R8 register 0", dbgRegData, 32'd0);

    // R2: operation code 11 acts as OR
    applyOp(mkI(5'd1, 5'd2, {5'd9, 11'd0}), 1, 0, 0, 2'b11, 0, 1, 0, "R2 code 11");
    // R3: sign extension of a negative immediate with or
    applyOp(mkI(5'd0, 5'd10, 16'h8001), 0, 1, 1, 2'b10, 0, 1, 0, "R3 sign-ext");
    // R6: load with register destination field rd ignored (regDst 0)
    applyOp(mkI(5'd0, 5'd11, 16'h0224), 0, 0, 1, 2'b00, 1, 1, 0, "R6 load");
    // R5: regWr 0 with a register op leaves state alone
    applyOp(mkI(5'd1, 5'd2, {5'd12, 11'd0}), 1, 0, 0, 2'b00, 0, 0, 0, "R5 no write");
    cmpState("R5 registers after directed", "R7 memory after directed");

    // R1: reset mid-run clears registers, memory retained
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) refReg[i] = '0;
    cmpState("R1 registers under reset", "R1 memory kept over reset");
    rstN = 1'b1;
    applyOp(mkI(5'd0, 5'd13, 16'h0008), 0, 0, 1, 2'b00, 1, 1, 0, "R6 load after reset");
    cmpState("R1 registers after reset", "R1 memory after reset");

    finishRun();
  end
endmodule